// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block holds a small group of interval timer channels, each with an up-counter compared against a programmable limit. A single free-running prescaler feeds every channel. Each channel picks one of four division ratios and advances its counter once per selected tick while its run bit is set. When the counter equals the limit, the next tick takes it back to zero and sets a sticky match flag. An interrupt line per channel follows that flag when the channel's interrupt-enable bit is set. Software clears the flag by writing the control word back with the flag bit at zero.

A parameter selects between a 16-bit and a 32-bit counter. Both variants keep a 16-bit control word, but the match flag and the interrupt-enable bit sit at different positions in it. Only the wide variant has a second flag that records the counter rolling past all ones without a match. A counter write from the bus does not reach the counter at once. It waits in a holding register until the channel's selected tick has occurred twice, and a busy bit is readable for that time. Software therefore polls the busy bit before it writes the counter again.

Top module: `cmt_timer`

## Requirements
- R1: While a channel runs, its counter rises by one on each selected tick. On the tick after the counter equals the compare value, the counter returns to zero and the match flag sets, so consecutive match flags are (compare + 1) × divisor bus-clock cycles apart.
- R2: Control bits [1:0] select the divisor: 0 gives one count per 8 bus clocks, 1 gives 32, 2 gives 128 and 3 gives 512.
- R3: The run register at word address 0 holds one bit per channel, with bit c for channel c. A channel whose bit is clear holds its counter at its current value, and the other channels are not affected.
- R4: The match flag reads at control bit 7 in the 16-bit variant and at bit 15 in the 32-bit variant. In the 32-bit variant only, bit 14 sets when the counter rolls over from all ones without matching. In the 16-bit variant, bit 14 is plain storage.
- R5: Writing the control word with a flag bit at 0 clears that flag, and writing it with a 1 leaves the flag unchanged (a write never sets it). Every other bit except the read-only busy bit 4 reads back as written.
- R6: If a match sets a flag in the same cycle that a control write clears it, the flag stays set.
- R7: The channel interrupt is the AND of the match flag and the enable bit (bit 6 in the 16-bit variant, bit 5 in the 32-bit variant), registered one cycle later. It stays high until the flag is cleared, and writing 0 to the control word drops it.
- R8: A counter write takes effect on the second selected tick after it. Until then, reads return the old count and busy (bit 4) reads 1.
- R9: A counter write made while busy is 1 is ignored.
- R10: After reset, counters read 0, compare registers read all ones, control words and the run register read 0, and interrupts are low.
- R11: Channel c's control word is at word address 4(c+1), its counter at 4(c+1)+1 and its compare value at 4(c+1)+2. Read data appears on the clock edge that samples the read strobe, and compare writes take effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq | output | NCH (2) | Per-channel match interrupt |

## Verification
A match that sets a channel's flag can fall in the same bus cycle as a control write that clears it. The bench measures the match period from two interrupt rising edges, then times a clearing write so that it is captured on the exact edge of the next match. The result is judged by requiring the interrupt to stay high on every following cycle and the control word to read back with its flag set. A clear that won would show as a one-cycle dip in the interrupt.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int CSR_W    = 16;
  localparam int SEL_W    = 2;
  localparam int BUSY_BIT = 4;
  localparam int WRAP_BIT = 14;

  // match flag position depends on the counter width variant
  function automatic int match_bit(input int cnt_w);
    return (cnt_w > 16) ? 15 : 7;
  endfunction

  // interrupt enable position depends on the counter width variant
  function automatic int ie_bit(input int cnt_w);
    return (cnt_w > 16) ? 5 : 6;
  endfunction

  typedef enum logic [1:0] {
    PEND_IDLE = 2'd0,
    PEND_ONE  = 2'd1,
    PEND_TWO  = 2'd2
  } pend_e;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int NSEL = 4,
  parameter int BASE = 3,
  parameter int STEP = 2
) (
  input  logic            clk,
  input  logic            rst,
  output logic [NSEL-1:0] tick
);
  localparam int PW = BASE + STEP * (NSEL - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  // tap k fires once every 2**(BASE+STEP*k) cycles
  generate
    for (genvar k = 0; k < NSEL; k++) begin : g_tap
      localparam int TW = BASE + STEP * k;
      assign tick[k] = &pre_q[TW-1:0];
    end
  endgenerate
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int NSEL  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [NSEL-1:0]  tick_in,
  input  logic             csr_we,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CSR_W-1:0] csr_out,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             irq_q,
  output logic             flag_o,
  output logic             ie_o,
  output logic             busy_o
);
  localparam int MB       = match_bit(CNT_W);
  localparam int IEB      = ie_bit(CNT_W);
  localparam bit HAS_WRAP = (CNT_W > 16);
  localparam logic [CSR_W-1:0] MATCH_M = CSR_W'(1) << MB;
  localparam logic [CSR_W-1:0] WRAP_M  = HAS_WRAP ? (CSR_W'(1) << WRAP_BIT) : '0;
  localparam logic [CSR_W-1:0] BUSY_M  = CSR_W'(1) << BUSY_BIT;
  localparam logic [CSR_W-1:0] KEEP_M  = ~(MATCH_M | WRAP_M | BUSY_M);

  logic [CSR_W-1:0] cfg_q;
  logic             match_q;
  logic             wrap_q;
  pend_e            pend_q;
  logic [CNT_W-1:0] pend_val;
  logic             tick, apply, step, hit, roll;

  assign tick  = tick_in[cfg_q[SEL_W-1:0]];
  assign apply = tick && (pend_q == PEND_ONE);
  assign step  = tick && run && !apply;
  assign hit   = step && (cnt_q == cmp_q);
  assign roll  = step && !hit && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      cmp_q <= '1;
    end else begin
      if (csr_we) cfg_q <= wdata[CSR_W-1:0] & KEEP_M;
      if (cmp_we) cmp_q <= wdata;
    end
  end

  // set has priority over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      if (hit)         match_q <= 1'b1;
      else if (csr_we) match_q <= match_q & wdata[MB];
      if (!HAS_WRAP)   wrap_q  <= 1'b0;
      else if (roll)   wrap_q  <= 1'b1;
      else if (csr_we) wrap_q  <= wrap_q & wdata[WRAP_BIT];
    end
  end

  // counter write waits for two ticks of the selected count clock
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= PEND_IDLE;
      pend_val <= '0;
    end else if (cnt_we && pend_q == PEND_IDLE) begin
      pend_q   <= PEND_TWO;
      pend_val <= wdata;
    end else if (tick) begin
      case (pend_q)
        PEND_TWO: pend_q <= PEND_ONE;
        PEND_ONE: pend_q <= PEND_IDLE;
        default:  pend_q <= PEND_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (apply) cnt_q <= pend_val;
    else if (step)  cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= match_q & cfg_q[IEB];
  end

  assign busy_o  = (pend_q != PEND_IDLE);
  assign flag_o  = match_q;
  assign ie_o    = cfg_q[IEB];
  assign csr_out = cfg_q | (match_q ? MATCH_M : '0) | (wrap_q ? WRAP_M : '0)
                 | (busy_o ? BUSY_M : '0);
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int NSEL   = 4,
  parameter int ADDR_W = $clog2(4 * (NCH + 1))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq
);
  localparam int MATCH_B = match_bit(CNT_W);

  logic [NSEL-1:0]      tick;
  logic [NCH-1:0]       run_q;
  logic [CSR_W-1:0]     csr_a [NCH];
  logic [CNT_W-1:0]     cnt_a [NCH];
  logic [CNT_W-1:0]     cmp_a [NCH];
  logic [NCH-1:0]       flag_v, ie_v, busy_v;
  logic [NCH*CNT_W-1:0] cnt_flat;
  logic [DATA_W-1:0]    rd_mux;
  logic                 clr_bit;

  assign clr_bit = bus_wdata[MATCH_B];

  cmt_prescaler #(.NSEL(NSEL)) u_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst)                           run_q <= '0;
    else if (bus_wr && bus_addr == '0) run_q <= bus_wdata[NCH-1:0];
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(4 * (c + 1));
      cmt_channel #(.CNT_W(CNT_W), .NSEL(NSEL)) u_ch (
        .clk    (clk),
        .rst    (rst),
        .run    (run_q[c]),
        .tick_in(tick),
        .csr_we (bus_wr && bus_addr == BASE),
        .cnt_we (bus_wr && bus_addr == BASE + 1'b1),
        .cmp_we (bus_wr && bus_addr == BASE + 2'd2),
        .wdata  (bus_wdata[CNT_W-1:0]),
        .csr_out(csr_a[c]),
        .cnt_q  (cnt_a[c]),
        .cmp_q  (cmp_a[c]),
        .irq_q  (irq[c]),
        .flag_o (flag_v[c]),
        .ie_o   (ie_v[c]),
        .busy_o (busy_v[c])
      );
      assign cnt_flat[c*CNT_W +: CNT_W] = cnt_a[c];
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (bus_addr == '0) rd_mux = DATA_W'(run_q);
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(4 * (c + 1)))     rd_mux = DATA_W'(csr_a[c]);
      if (bus_addr == ADDR_W'(4 * (c + 1) + 1)) rd_mux = DATA_W'(cnt_a[c]);
      if (bus_addr == ADDR_W'(4 * (c + 1) + 2)) rd_mux = DATA_W'(cmp_a[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk #(
  parameter int NCH    = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              clr_bit,
  input logic [NCH-1:0]    irq,
  input logic [NCH-1:0]    run_q,
  input logic [NCH-1:0]    flag_v,
  input logic [NCH-1:0]    ie_v,
  input logic [NCH-1:0]    busy_v,
  input logic [NCH*CNT_W-1:0] cnt_flat
);
  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq == '0))
    else $error("irq high right after reset");

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chk
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(4 * (c + 1));

      assert_irq_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_v[c] && ie_v[c]) |=> irq[c])
        else $error("irq missing for enabled flag");

      assert_irq_drops_R7: assert property (@(posedge clk) disable iff (rst)
        !(flag_v[c] && ie_v[c]) |=> !irq[c])
        else $error("irq without enabled flag");

      assert_flag_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_v[c]) |-> $past(bus_wr && bus_addr == BASE && !clr_bit))
        else $error("flag cleared without clearing write");

      assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (!run_q[c] && !busy_v[c]) |=> $stable(cnt_flat[c*CNT_W +: CNT_W]))
        else $error("stopped counter moved");

      assert_busy_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_v[c]) |-> $past(bus_wr && bus_addr == BASE + 1'b1))
        else $error("busy without counter write");
    end
  endgenerate
endmodule

bind cmt_timer cmt_timer_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr),
  .clr_bit (clr_bit),
  .irq     (irq),
  .run_q   (run_q),
  .flag_v  (flag_v),
  .ie_v    (ie_v),
  .busy_v  (busy_v),
  .cnt_flat(cnt_flat)
);

// File: tb/cmt_timer_test.sv
module cmt_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd32, rd16;
  logic [1:0]  irq32, irq16;
  int unsigned cyc = 0;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmt_timer uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd32), .irq(irq32)
  );

  cmt_timer #(.NCH(2), .CNT_W(16)) uut_w16 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd16), .irq(irq16)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v32, output logic [31:0] v16);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v32 = rd32; v16 = rd16;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected control word per variant (R4, R5)
  function automatic logic [31:0] exp_csr(input bit w32, input logic [15:0] w,
                                          input bit m, input bit o, input bit b);
    logic [15:0] r;
    r = w & (w32 ? 16'h3FEF : 16'hFF6F);
    if (w32) begin r[15] = m; r[14] = o; end
    else r[7] = m;
    r[4] = b;
    return {16'h0, r};
  endfunction

  task automatic wait_rise(input int ch, output int unsigned e);
    while (irq32[ch]) @(negedge clk);
    while (!irq32[ch]) @(negedge clk);
    e = cyc;
  endtask

  task automatic measure(input int ch, input int sel, input int cmpv, input bit collide);
    int unsigned dv, e1, e2, per, target;
    logic [3:0]  cb;
    logic [31:0] a, b;
    dv = 8 << (2 * sel);
    per = (cmpv + 1) * dv;
    cb = 4'(4 * (ch + 1));
    wr(4'd0, 32'd0);
    wr(cb, 32'h60 | sel);
    wr(cb + 4'd2, cmpv);
    wr(cb + 4'd1, 32'd0);
    idle(2 * dv + 4);
    wr(cb, 32'h60 | sel);
    wr(4'd0, 32'd1 << ch);
    wait_rise(ch, e1);
    chk("R1 variants match together", {31'd0, irq16[ch]}, 32'd1);
    idle(5);
    chk("R7 irq held while flag set", {30'd0, irq32[ch], irq16[ch]}, 32'd3);
    wr(cb, 32'h60 | sel);
    wait_rise(ch, e2);
    chk("R1 R2 match period", e2 - e1, per);
    rd(cb, a, b);
    chk("R4 flag position wide", a, exp_csr(1, 16'(32'h60 | sel), 1, 0, 0));
    chk("R4 flag position narrow", b, exp_csr(0, 16'(32'h60 | sel), 1, 0, 0));
    if (collide) begin
      // next flag set lands on edge e2-1+per: capture the clear on that edge
      target = e2 - 2 + per;
      while (cyc < target) @(negedge clk);
      bus_wr = 1'b1; bus_addr = cb; bus_wdata = 32'h60 | sel;
      @(negedge clk);
      bus_wr = 1'b0;
      for (int i = 0; i < 4; i++) begin
        chk("R6 set beats clear, irq stays", {30'd0, irq32[ch], irq16[ch]}, 32'd3);
        @(negedge clk);
      end
      rd(cb, a, b);
      chk("R6 flag kept wide", a, exp_csr(1, 16'(32'h60 | sel), 1, 0, 0));
      chk("R6 flag kept narrow", b, exp_csr(0, 16'(32'h60 | sel), 1, 0, 0));
    end
    wr(4'd0, 32'd0);
    wr(cb, 32'h60 | sel);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, c0, c1;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R10 reset state, R11 map
    rd(4'd0, a, b);  chk("R10 run reg", a, 0); chk("R10 run reg narrow", b, 0);
    rd(4'd4, a, b);  chk("R10 ctrl", a, 0); chk("R10 ctrl narrow", b, 0);
    rd(4'd5, a, b);  chk("R10 count", a, 0); chk("R10 count narrow", b, 0);
    rd(4'd10, a, b); chk("R10 R11 compare all ones", a, 32'hFFFF_FFFF);
    chk("R10 R11 compare all ones narrow", b, 32'h0000_FFFF);
    chk("R10 irq low", {30'd0, irq32[0], irq16[0]}, 0);

    // R5 readback with read-only and flag bits
    wr(4'd8, 32'hA5F3);
    rd(4'd8, a, b);
    chk("R5 ctrl readback wide", a, exp_csr(1, 16'hA5F3, 0, 0, 0));
    chk("R5 ctrl readback narrow", b, exp_csr(0, 16'hA5F3, 0, 0, 0));
    wr(4'd8, 32'd0);

    // R8 delayed counter write, R9 write while busy ignored
    wr(4'd4, 32'd0);
    wr(4'd5, 32'h1234);
    wr(4'd5, 32'h0777);
    rd(4'd5, a, b);
    chk("R8 old count before apply", a, 0); chk("R8 old count narrow", b, 0);
    rd(4'd4, a, b);
    chk("R8 busy while pending", a, exp_csr(1, 16'h0, 0, 0, 1));
    chk("R8 busy narrow", b, exp_csr(0, 16'h0, 0, 0, 1));
    idle(20);
    rd(4'd5, a, b);
    chk("R8 R9 first write applied", a, 32'h1234); chk("R9 narrow", b, 32'h1234);
    rd(4'd4, a, b);
    chk("R8 busy cleared", a, 0);

    // R3 run bits independent, stopped counter frozen
    wr(4'd5, 32'd0);
    idle(20);
    wr(4'd6, 32'd200);
    wr(4'd0, 32'd1);
    idle(100);
    rd(4'd9, a, b);
    chk("R3 stopped channel 1 holds", a, 0);
    rd(4'd5, c0, b);
    chk("R3 R1 running channel 0 advanced", {31'd0, (c0 > 32'd5)}, 1);
    chk("R1 narrow same count", b, c0);
    wr(4'd0, 32'd0);
    rd(4'd5, c0, b);
    idle(40);
    rd(4'd5, c1, b);
    chk("R3 stopped channel 0 frozen", c1, c0);

    // R1 R2 R6 R7 periods
    measure(0, 0, 7, 1'b1);
    measure(1, 3, 2, 1'b0);
    measure(0, 1, 4, 1'b0);
    for (int i = 0; i < 5; i++)
      measure($urandom_range(0, 1), $urandom_range(0, 2), $urandom_range(3, 24), 1'b0);

    // R7 enable gating, write of zero disables
    wr(4'd8, 32'd0);
    wr(4'd10, 32'd3);
    wr(4'd9, 32'd0);
    idle(20);
    wr(4'd0, 32'd2);
    idle(100);
    chk("R7 no irq without enable", {30'd0, irq32[1], irq16[1]}, 0);
    rd(4'd8, a, b);
    chk("R7 flag set though masked", a, exp_csr(1, 16'h0, 1, 0, 0));
    chk("R7 flag set narrow", b, exp_csr(0, 16'h0, 1, 0, 0));
    wr(4'd8, 32'h80E0);
    idle(3);
    chk("R7 irq on enable", {30'd0, irq32[1], irq16[1]}, 32'd3);
    wr(4'd8, 32'd0);
    idle(3);
    chk("R7 zero write drops irq", {30'd0, irq32[1], irq16[1]}, 0);
    wr(4'd0, 32'd0);

    // R4 rollover flag in the wide variant only
    wr(4'd4, 32'd0);
    wr(4'd6, 32'd5);
    wr(4'd5, 32'hFFFF_FFFC);
    idle(20);
    wr(4'd0, 32'd1);
    idle(48);
    rd(4'd4, a, b);
    chk("R4 wrap flag wide", a, exp_csr(1, 16'h0, 0, 1, 0));
    chk("R4 no wrap flag narrow", b, exp_csr(0, 16'h0, 0, 0, 0));
    wr(4'd0, 32'd0);
    wr(4'd4, 32'd0);
    rd(4'd4, a, b);
    chk("R4 R5 both flags cleared", a, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule